// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block compares two IEEE-754 values and turns the result into a four-bit condition code: negative, zero, carry and overflow. The two values are both single precision or both double precision. The code is written into the top nibble of a 32-bit floating-point status word, and the lower 28 bits of that word pass through unchanged. A select input replaces the second operand with zero, so the first operand can be tested against zero without loading a constant.

The compare works on the sign-magnitude encodings directly, with no subtraction datapath. NaNs and infinities are classified from the exponent and fraction fields. Two infinities of the same sign give the equal code. The two zeros are treated as the same value. The caller pulses a start strobe with the operands and the current status word. One clock later the block presents the updated word with a one-cycle valid pulse. It holds that word until the next start.

Top module: `fpcmp_flags`

## Requirements
- R1: `valid_out` is high in exactly the cycle after a cycle in which `start` was high, and is low otherwise.
- R2: On a start, `status_out[27:0]` takes the `status_in[27:0]` of that cycle. While `start` stays low, `status_out` keeps its value.
- R3: When the first operand is less than the second, `status_out[31:28]` (N,Z,C,V from bit 31 down) becomes 4'b1000.
- R4: When the operands are equal, `status_out[31:28]` becomes 4'b0110.
- R5: When the first operand is greater than the second, `status_out[31:28]` becomes 4'b0010.
- R6: When either operand is a NaN (exponent all ones, fraction nonzero, quiet or signalling), `status_out[31:28]` becomes 4'b0011.
- R7: Two infinities of the same sign give the equal code. Infinities of opposite sign give the less code when the first operand is negative and the greater code when it is positive.
- R8: Positive zero and negative zero compare equal in every pairing.
- R9: With `zero_sel` high, `op_b` is ignored and the first operand is compared against positive zero.
- R10: With `dbl_sel` high, both operands are 64-bit doubles. With `dbl_sel` low, only bits 31:0 are used as singles and bits 63:32 have no effect.
- R11: While reset is held, `status_out` is zero and `valid_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a compare with the current inputs |
| dbl_sel | input | 1 | 1: double operands, 0: single operands in bits 31:0 |
| zero_sel | input | 1 | 1: compare the first operand against +0 |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| status_in | input | 32 | Current status word; bits 27:0 are kept |
| status_out | output | 32 | Updated status word with flags in bits 31:28 |
| valid_out | output | 1 | One-cycle pulse when status_out is updated |

## Verification
A wrong classification shows up in the flag nibble in the cycle right after the start strobe. A fraction bit missed in NaN detection turns the 0011 code into an ordered code. A sign handled wrongly in the magnitude path swaps 1000 and 0010 for one sign quadrant only. The bench sweeps every ordered pair from a set of sixteen boundary encodings in both precisions, so each of these faults appears in the first pass over the affected class. Corruption of the pass-through bits, or a missing hold, appears on the same cycle against the randomized status word.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int DBL_W    = 64;
    localparam int SGL_W    = 32;
    localparam int DBL_EXP  = 11;
    localparam int DBL_FRAC = 52;
    localparam int SGL_EXP  = 8;
    localparam int SGL_FRAC = 23;
    localparam int MAG_W    = DBL_W - 1;
    localparam int STAT_W   = 32;
    localparam int FLAG_W   = 4;
    localparam int KEEP_W   = STAT_W - FLAG_W;

    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } fp_rel_e;

    typedef struct packed {
        logic             sign;
        logic             is_zero;
        logic             is_inf;
        logic             is_nan;
        logic [MAG_W-1:0] mag;
    } fp_class_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic nzcv_t rel_to_flags(input fp_rel_e rel);
        nzcv_t f;
        case (rel)
            REL_LT:  f = '{n: 1'b1, z: 1'b0, c: 1'b0, v: 1'b0};
            REL_EQ:  f = '{n: 1'b0, z: 1'b1, c: 1'b1, v: 1'b0};
            REL_GT:  f = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b0};
            default: f = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b1};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
    import fpcmp_pkg::*;
(
    input  logic [DBL_W-1:0] operand,
    input  logic             dbl_sel,
    output fp_class_t        cls
);
    localparam int DE_LO = DBL_FRAC;
    localparam int SE_LO = SGL_FRAC;

    fp_class_t d_cls;
    fp_class_t s_cls;

    always_comb begin
        d_cls.sign    = operand[DBL_W-1];
        d_cls.mag     = operand[MAG_W-1:0];
        d_cls.is_zero = (operand[MAG_W-1:0] == '0);
        d_cls.is_inf  = (&operand[DE_LO +: DBL_EXP]) && (operand[DBL_FRAC-1:0] == '0);
        d_cls.is_nan  = (&operand[DE_LO +: DBL_EXP]) && (operand[DBL_FRAC-1:0] != '0);
    end

    always_comb begin
        s_cls.sign    = operand[SGL_W-1];
        s_cls.mag     = {{(MAG_W-SGL_W+1){1'b0}}, operand[SGL_W-2:0]};
        s_cls.is_zero = (operand[SGL_W-2:0] == '0);
        s_cls.is_inf  = (&operand[SE_LO +: SGL_EXP]) && (operand[SGL_FRAC-1:0] == '0);
        s_cls.is_nan  = (&operand[SE_LO +: SGL_EXP]) && (operand[SGL_FRAC-1:0] != '0);
    end

    assign cls = dbl_sel ? d_cls : s_cls;

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  fp_class_t a,
    input  fp_class_t b,
    output fp_rel_e   rel
);
    logic mag_lt;
    logic mag_eq;

    assign mag_lt = (a.mag < b.mag);
    assign mag_eq = (a.mag == b.mag);

    always_comb begin
        if (a.is_nan || b.is_nan)
            rel = REL_UN;
        else if (a.is_zero && b.is_zero)
            rel = REL_EQ;
        else if (a.sign != b.sign)
            rel = a.sign ? REL_LT : REL_GT;
        else if (mag_eq)
            rel = REL_EQ;
        else if (mag_lt ^ a.sign)
            rel = REL_LT;
        else
            rel = REL_GT;
    end

    always_comb begin
        if (!a.is_nan && !b.is_nan && a.is_inf && b.is_inf && (a.sign == b.sign))
            assert_inf_same_sign_R7: assert (rel == REL_EQ);
    end

endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dbl_sel,
    input  logic              zero_sel,
    input  logic [DBL_W-1:0]  op_a,
    input  logic [DBL_W-1:0]  op_b,
    input  logic [STAT_W-1:0] status_in,
    output logic [STAT_W-1:0] status_out,
    output logic              valid_out
);
    localparam logic [STAT_W-1:0] KEEP_MASK = {{FLAG_W{1'b0}}, {KEEP_W{1'b1}}};

    logic [DBL_W-1:0]  opnd [2];
    fp_class_t         cls  [2];
    fp_rel_e           rel;
    nzcv_t             flags;
    logic [STAT_W-1:0] status_d;
    logic [STAT_W-1:0] status_q;
    logic              valid_q;

    assign opnd[0] = op_a;
    assign opnd[1] = zero_sel ? '0 : op_b;

    for (genvar i = 0; i < 2; i++) begin : g_unpack
        fpcmp_unpack u_unpack (
            .operand (opnd[i]),
            .dbl_sel (dbl_sel),
            .cls     (cls[i])
        );
    end

    fpcmp_order u_order (
        .a   (cls[0]),
        .b   (cls[1]),
        .rel (rel)
    );

    assign flags    = rel_to_flags(rel);
    assign status_d = {flags, {KEEP_W{1'b0}}} | (status_in & KEEP_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= start;
            if (start)
                status_q <= status_d;
        end
    end

    assign status_out = status_q;
    assign valid_out  = valid_q;

    assert_valid_after_start_R1: assert property (@(posedge clk) disable iff (rst)
        start |=> valid_out);
    assert_no_stray_valid_R1: assert property (@(posedge clk) disable iff (rst)
        !start |=> !valid_out);
    assert_low_bits_kept_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> status_out[KEEP_W-1:0] == $past(status_in[KEEP_W-1:0]));
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(status_out));
    assert_nan_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (start && (cls[0].is_nan || cls[1].is_nan)) |=> status_out[STAT_W-1 -: FLAG_W] == 4'b0011);
    assert_zero_pair_equal_R8: assert property (@(posedge clk) disable iff (rst)
        (start && cls[0].is_zero && cls[1].is_zero) |=> status_out[STAT_W-1 -: FLAG_W] == 4'b0110);
    assert_one_code_R4: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> $countones(status_out[STAT_W-1 -: FLAG_W]) inside {1, 2});

endmodule

// File: tb/fpcmp_flags_bench.sv
module fpcmp_flags_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dbl_sel = 1'b0;
    logic        zero_sel = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [31:0] status_in = '0;
    logic [31:0] status_out;
    logic        valid_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpcmp_flags u_fpcmp_flags (
        .clk(clk), .rst(rst), .start(start), .dbl_sel(dbl_sel), .zero_sel(zero_sel),
        .op_a(op_a), .op_b(op_b), .status_in(status_in),
        .status_out(status_out), .valid_out(valid_out)
    );

    function automatic logic [63:0] pick(input int k, input bit dbl);
        logic [63:0] d;
        logic [31:0] s;
        case (k)
            0:  begin d = 64'h0000_0000_0000_0000; s = 32'h0000_0000; end
            1:  begin d = 64'h8000_0000_0000_0000; s = 32'h8000_0000; end
            2:  begin d = 64'h0000_0000_0000_0001; s = 32'h0000_0001; end
            3:  begin d = 64'h8000_0000_0000_0001; s = 32'h8000_0001; end
            4:  begin d = 64'h3FF0_0000_0000_0000; s = 32'h3F80_0000; end
            5:  begin d = 64'hBFF0_0000_0000_0000; s = 32'hBF80_0000; end
            6:  begin d = 64'h4000_0000_0000_0000; s = 32'h4000_0000; end
            7:  begin d = 64'hC000_0000_0000_0000; s = 32'hC000_0000; end
            8:  begin d = 64'h7FEF_FFFF_FFFF_FFFF; s = 32'h7F7F_FFFF; end
            9:  begin d = 64'hFFEF_FFFF_FFFF_FFFF; s = 32'hFF7F_FFFF; end
            10: begin d = 64'h7FF0_0000_0000_0000; s = 32'h7F80_0000; end
            11: begin d = 64'hFFF0_0000_0000_0000; s = 32'hFF80_0000; end
            12: begin d = 64'h7FF8_0000_0000_0000; s = 32'h7FC0_0000; end
            13: begin d = 64'h7FF0_0000_0000_0001; s = 32'h7F80_0001; end
            14: begin d = 64'hFFF8_0000_0000_0000; s = 32'hFFC0_0000; end
            default: begin d = 64'h3FF0_0000_0000_0001; s = 32'h3F80_0001; end
        endcase
        return dbl ? d : {$urandom(), s};
    endfunction

    function automatic void fields(input logic [63:0] v, input bit dbl,
                                   output bit sg, output int ex, output longint fr,
                                   output int emax, output int bias, output int fw);
        if (dbl) begin
            sg = v[63]; ex = int'(v[62:52]); fr = longint'(v[51:0]);
            emax = 2047; bias = 1023; fw = 52;
        end else begin
            sg = v[31]; ex = int'(v[30:23]); fr = longint'(v[22:0]);
            emax = 255; bias = 127; fw = 23;
        end
    endfunction

    function automatic real to_real(input logic [63:0] v, input bit dbl);
        bit sg; int ex; longint fr; int emax; int bias; int fw;
        longint mant; int sh; real r;
        fields(v, dbl, sg, ex, fr, emax, bias, fw);
        mant = (ex == 0) ? fr : fr + (longint'(1) << fw);
        sh = ((ex == 0) ? 1 : ex) - bias - fw;
        r = real'(mant);
        if (sh > 0) for (int i = 0; i < sh; i++) r = r * 2.0;
        else        for (int i = 0; i < -sh; i++) r = r / 2.0;
        return sg ? -r : r;
    endfunction

    function automatic bit is_nan(input logic [63:0] v, input bit dbl);
        bit sg; int ex; longint fr; int emax; int bias; int fw;
        fields(v, dbl, sg, ex, fr, emax, bias, fw);
        return (ex == emax) && (fr != 0);
    endfunction

    function automatic bit is_inf(input logic [63:0] v, input bit dbl);
        bit sg; int ex; longint fr; int emax; int bias; int fw;
        fields(v, dbl, sg, ex, fr, emax, bias, fw);
        return (ex == emax) && (fr == 0);
    endfunction

    // Expected nibble and the requirement tag that covers the case.
    function automatic logic [3:0] expect_code(input logic [63:0] a, input logic [63:0] b,
                                               input bit dbl, output string tag);
        bit sa, sb;
        real ra, rb;
        sa = dbl ? a[63] : a[31];
        sb = dbl ? b[63] : b[31];
        if (is_nan(a, dbl) || is_nan(b, dbl)) begin
            tag = "R6"; return 4'b0011;
        end
        if (is_inf(a, dbl) && is_inf(b, dbl)) begin
            tag = "R7";
            if (sa == sb) return 4'b0110;
            return sa ? 4'b1000 : 4'b0010;
        end
        if (is_inf(a, dbl)) begin tag = "R5"; return sa ? 4'b1000 : 4'b0010; end
        if (is_inf(b, dbl)) begin tag = "R3"; return sb ? 4'b0010 : 4'b1000; end
        ra = to_real(a, dbl);
        rb = to_real(b, dbl);
        if (ra < rb) begin tag = "R3"; return 4'b1000; end
        if (ra > rb) begin tag = "R5"; return 4'b0010; end
        tag = (ra == 0.0) ? "R8" : "R4";
        return 4'b0110;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_cmp(input logic [63:0] a, input logic [63:0] b, input bit dbl,
                           input bit zsel, input string tag_over);
        logic [31:0] st;
        logic [3:0]  code;
        string       tag;
        logic [63:0] beff;
        beff = zsel ? 64'd0 : b;
        code = expect_code(a, beff, dbl, tag);
        if (tag_over != "") tag = tag_over;
        st = $urandom();
        @(negedge clk);
        op_a = a; op_b = b; dbl_sel = dbl; zero_sel = zsel; status_in = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a = $urandom(); op_b = $urandom(); status_in = $urandom();
        check(valid_out === 1'b1, "R1", 64'(valid_out), 64'd1);
        check(status_out[31:28] === code, dbl ? {tag, " R10"} : {tag, " R10 single"},
              64'(status_out[31:28]), 64'(code));
        check(status_out[27:0] === st[27:0], "R2", 64'(status_out[27:0]), 64'(st[27:0]));
    endtask

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check(status_out === 32'd0, "R11", 64'(status_out), 64'd0);
        check(valid_out === 1'b0, "R11", 64'(valid_out), 64'd0);
        rst = 1'b0;

        // Near-exhaustive pair sweep in both precisions (R3-R8, R10).
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    run_cmp(pick(i, p[0]), pick(j, p[0]), p[0], 1'b0, "");

        // Compare against zero with a garbage second operand (R9).
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 16; i++)
                run_cmp(pick(i, p[0]), 64'h7FF8_0000_0000_0000 | 64'($urandom()), p[0], 1'b1, "R9");

        // Idle cycles: no valid, status held (R1, R2).
        held = status_out;
        @(negedge clk);
        check(valid_out === 1'b0, "R1", 64'(valid_out), 64'd0);
        repeat (3) @(negedge clk);
        check(status_out === held, "R2", 64'(status_out), 64'(held));
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule